// File: doc/BRIEF.md
# Rate-Paced DMA Bus-Hold Controller

This block tracks a copy-type DMA transfer inside a video processor. Software loads a word count and then issues a start command. From that point the block asserts a bus request to the host CPU and holds it until the last word has moved. While the bus is granted, a rate accumulator paces the transfer and emits one word strobe each time enough master-clock credit has built up.

The pace depends on the blanking condition. When vertical blanking is active or the display is disabled, the fast blanked rate applies. Otherwise the slower active-display rate applies. The condition is evaluated on every master-clock enable, so a change of vertical blanking in the middle of a transfer alters the pace at once.

A display-enable write that arrives while a transfer runs is held back. It takes effect on the cycle the bus request drops, so the transfer keeps the rate it started with. This matters when software turns the display back on in the second half of a 32-bit write whose first half started the DMA.

Top module: `dma_pacer`

## Requirements
- R1: After reset, bus_req_o, word_stb_o and disp_en_o are 0 and no transfer is in progress.
- R2: A write with wr_kind_i = 2'b10 (start) while idle raises bus_req_o on the next cycle. A start write during a transfer is ignored.
- R3: A length of 0 (written with wr_kind_i = 2'b00 in wr_data_i[15:0]) runs as a 65536-word transfer, so the request stays up long after any 16-bit count could have finished.
- R4: On each cycle with bus_req_o, mclk_en_i and bus_gnt_i all high, the current rate is added to an accumulator. When the sum reaches LINE_CLKS (3420), one word strobe is issued on the next cycle and 3420 is subtracted. The request drops with the last strobe. A 16-word blanked transfer at 205 words per line keeps bus_req_o high for 267 cycles.
- R5: While vblank_i is 0 and disp_en_o is 1, the rate is RATE_ACTIVE (18). A 4-word transfer then holds the request for 760 cycles.
- R6: The rate is taken from vblank_i on every step, so a change of vblank_i during a transfer changes the pace from the next step on.
- R7: A write with wr_kind_i = 2'b01 sets the display enable from wr_data_i[0]. When idle, disp_en_o shows the value on the next cycle. During a transfer the last written value is held and appears on the same cycle bus_req_o falls, and disp_en_o stays stable until then.
- R8: No credit accrues and no strobe is issued on a cycle without bus_gnt_i or without mclk_en_i.
- R9: A length write during a transfer does not change the running transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mclk_en_i | input | 1 | Master-clock enable, one pacing step per high cycle |
| wr_en_i | input | 1 | Register write strobe |
| wr_kind_i | input | 2 | 00 length, 01 display mode, 10 start, 11 no effect |
| wr_data_i | input | 16 | Write data |
| vblank_i | input | 1 | Vertical blanking active |
| bus_gnt_i | input | 1 | Host bus grant |
| bus_req_o | output | 1 | Host bus request, high for the whole transfer |
| word_stb_o | output | 1 | One-cycle pulse per word moved |
| disp_en_o | output | 1 | Applied display enable |

## Verification
All results are registered. A start shows up on bus_req_o one cycle after the write edge. A strobe appears one cycle after the step that crossed the line total, and the last strobe coincides with the fall of bus_req_o and with any deferred disp_en_o update. An idle mode write reaches disp_en_o one cycle after the write. The reference model advances on the rising edge from the same inputs the design samples. Outputs are compared on the falling edge, and transfer durations are counted in falling edges while the request is high, which matches the cycle totals given in R4 and R5.

// File: rtl/dma_pacer_pkg.sv
package dma_pacer_pkg;
  typedef enum logic [1:0] {
    WK_LEN   = 2'b00,
    WK_MODE  = 2'b01,
    WK_START = 2'b10,
    WK_NONE  = 2'b11
  } wr_kind_e;
endpackage

// File: rtl/dma_cmd_regs.sv
module dma_cmd_regs
  import dma_pacer_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_kind_i,
  input  logic [15:0]      wr_data_i,
  input  logic             busy_i,
  input  logic             done_i,
  output logic             start_o,
  output logic [LEN_W-1:0] len_o,
  output logic             disp_o
);
  wr_kind_e kind;
  logic [LEN_W-1:0] len_q;
  logic disp_q, pend_q, pval_q;
  logic pend_n, pval_n;

  assign kind    = wr_kind_e'(wr_kind_i);
  assign start_o = wr_en_i && kind == WK_START && !busy_i;
  assign len_o   = len_q;
  assign disp_o  = disp_q;

  // a mode write landing on the final step still wins
  always_comb begin
    pend_n = pend_q;
    pval_n = pval_q;
    if (wr_en_i && kind == WK_MODE && busy_i) begin
      pend_n = 1'b1;
      pval_n = wr_data_i[0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q  <= '0;
      disp_q <= 1'b0;
      pend_q <= 1'b0;
      pval_q <= 1'b0;
    end else begin
      if (wr_en_i && kind == WK_LEN && !busy_i) len_q <= wr_data_i[LEN_W-1:0];
      if (wr_en_i && kind == WK_MODE && !busy_i) disp_q <= wr_data_i[0];
      if (done_i) begin
        if (pend_n) disp_q <= pval_n;
        pend_q <= 1'b0;
      end else begin
        pend_q <= pend_n;
      end
      pval_q <= pval_n;
    end
  end
endmodule

// File: rtl/dma_rate_acc.sv
module dma_rate_acc #(
  parameter int LINE_CLKS   = 3420,
  parameter int RATE_BLANK  = 205,
  parameter int RATE_ACTIVE = 18
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic step_i,
  input  logic blank_i,
  output logic tick_o
);
  localparam int RATE_MAX = (RATE_BLANK > RATE_ACTIVE) ? RATE_BLANK : RATE_ACTIVE;
  localparam int ACC_W    = $clog2(LINE_CLKS + RATE_MAX + 1);
  localparam logic [ACC_W-1:0] LINE_V = ACC_W'(LINE_CLKS);

  logic [ACC_W-1:0] acc_q, rate, sum;

  generate
    if (RATE_BLANK == RATE_ACTIVE) begin : g_fixed
      assign rate = ACC_W'(RATE_BLANK);
    end else begin : g_sel
      assign rate = blank_i ? ACC_W'(RATE_BLANK) : ACC_W'(RATE_ACTIVE);
    end
  endgenerate

  assign sum    = acc_q + rate;
  assign tick_o = step_i && (sum >= LINE_V);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (clr_i)  acc_q <= '0;
    else if (step_i) acc_q <= tick_o ? sum - LINE_V : sum;
  end
endmodule

// File: rtl/dma_word_cnt.sv
module dma_word_cnt #(
  parameter int LEN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             tick_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             stb_o
);
  localparam int CNT_W = LEN_W + 1;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(1) << LEN_W;

  logic [CNT_W-1:0] left_q;
  logic busy_q, stb_q;

  assign busy_o = busy_q;
  assign stb_o  = stb_q;
  assign done_o = tick_i && left_q == CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q <= '0;
      busy_q <= 1'b0;
      stb_q  <= 1'b0;
    end else begin
      stb_q <= tick_i;
      if (load_i) begin
        left_q <= (len_i == '0) ? FULL : {1'b0, len_i};
        busy_q <= 1'b1;
      end else if (tick_i) begin
        left_q <= left_q - CNT_W'(1);
        if (done_o) busy_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dma_pacer.sv
module dma_pacer #(
  parameter int LINE_CLKS   = 3420,
  parameter int RATE_BLANK  = 205,
  parameter int RATE_ACTIVE = 18,
  parameter int LEN_W       = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        mclk_en_i,
  input  logic        wr_en_i,
  input  logic [1:0]  wr_kind_i,
  input  logic [15:0] wr_data_i,
  input  logic        vblank_i,
  input  logic        bus_gnt_i,
  output logic        bus_req_o,
  output logic        word_stb_o,
  output logic        disp_en_o
);
  logic busy, done, start, tick, step, blank, disp;
  logic [LEN_W-1:0] len;

  assign step      = busy && mclk_en_i && bus_gnt_i;
  assign blank     = vblank_i || !disp;
  assign bus_req_o = busy;
  assign disp_en_o = disp;

  dma_cmd_regs #(.LEN_W(LEN_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_kind_i(wr_kind_i),
    .wr_data_i(wr_data_i), .busy_i(busy), .done_i(done),
    .start_o(start), .len_o(len), .disp_o(disp)
  );

  dma_rate_acc #(.LINE_CLKS(LINE_CLKS), .RATE_BLANK(RATE_BLANK), .RATE_ACTIVE(RATE_ACTIVE)) u_acc (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(start), .step_i(step),
    .blank_i(blank), .tick_o(tick)
  );

  dma_word_cnt #(.LEN_W(LEN_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(start), .len_i(len), .tick_i(tick),
    .busy_o(busy), .done_o(done), .stb_o(word_stb_o)
  );
endmodule

// File: rtl/dma_pacer_chk.sv
module dma_pacer_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       mclk_en_i,
  input logic       wr_en_i,
  input logic [1:0] wr_kind_i,
  input logic       bus_gnt_i,
  input logic       bus_req_o,
  input logic       word_stb_o,
  input logic       disp_en_o
);
  // R2
  start_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_kind_i == 2'b10 && !bus_req_o) |=> bus_req_o);

  // R8
  stb_needs_gnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_stb_o |-> $past(bus_gnt_i && mclk_en_i && bus_req_o));

  // R7
  disp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && $past(bus_req_o)) |-> $stable(disp_en_o));

  // R4
  release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bus_req_o) |-> word_stb_o);
endmodule

bind dma_pacer dma_pacer_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mclk_en_i(mclk_en_i), .wr_en_i(wr_en_i),
  .wr_kind_i(wr_kind_i), .bus_gnt_i(bus_gnt_i), .bus_req_o(bus_req_o),
  .word_stb_o(word_stb_o), .disp_en_o(disp_en_o)
);

// File: tb/sim_dma_pacer.sv
module sim_dma_pacer;
  logic clk = 0, rst_ni = 0;
  logic mclk_en = 1, wr_en = 0, vblank = 0, gnt = 1;
  logic [1:0] kind = 2'b11;
  logic [15:0] wdata = '0;
  logic bus_req, stb, disp;
  int errors = 0, checks = 0;
  string tag = "R1";

  always #4 clk = ~clk;

  dma_pacer u0 (
    .clk_i(clk), .rst_ni(rst_ni), .mclk_en_i(mclk_en), .wr_en_i(wr_en),
    .wr_kind_i(kind), .wr_data_i(wdata), .vblank_i(vblank), .bus_gnt_i(gnt),
    .bus_req_o(bus_req), .word_stb_o(stb), .disp_en_o(disp)
  );

  // behavioural reference
  int m_left, m_acc, m_len;
  bit m_busy, m_stb, m_disp, m_pend, m_pval;
  always @(posedge clk) begin
    if (!rst_ni) begin
      m_left = 0; m_acc = 0; m_len = 0;
      m_busy = 0; m_stb = 0; m_disp = 0; m_pend = 0; m_pval = 0;
    end else begin
      bit was_busy, fin;
      int rate;
      was_busy = m_busy; fin = 0; m_stb = 0;
      if (was_busy && mclk_en && gnt) begin
        rate = (vblank || !m_disp) ? 205 : 18;
        m_acc += rate;
        if (m_acc >= 3420) begin
          m_acc -= 3420; m_stb = 1; m_left--;
          if (m_left == 0) fin = 1;
        end
      end
      if (wr_en) begin
        if (kind == 2'b00 && !was_busy) m_len = wdata;
        if (kind == 2'b01) begin
          if (was_busy) begin m_pend = 1; m_pval = wdata[0]; end
          else m_disp = wdata[0];
        end
        if (kind == 2'b10 && !was_busy) begin
          m_busy = 1; m_acc = 0; m_left = (m_len == 0) ? 65536 : m_len;
        end
      end
      if (fin) begin
        m_busy = 0;
        if (m_pend) m_disp = m_pval;
        m_pend = 0;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_ni) begin
    chk({tag, " bus_req"}, bus_req, m_busy);
    chk({tag, " word_stb"}, stb, m_stb);
    chk({tag, " disp_en"}, disp, m_disp);
  end

  task automatic report;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    report();
  end

  task automatic wr(input logic [1:0] k, input logic [15:0] d);
    @(negedge clk); wr_en = 1; kind = k; wdata = d;
    @(negedge clk); wr_en = 0; kind = 2'b11;
  endtask

  int n, ns;

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 bus_req", bus_req, 0);
    chk("R1 word_stb", stb, 0);
    chk("R1 disp_en", disp, 0);
    rst_ni = 1;

    // blanked 16 words, with length and start writes mid-transfer
    tag = "R4";
    wr(2'b00, 16'd16);
    wr(2'b10, 16'd0);
    chk("R2 request raised", bus_req, 1);
    n = 0; ns = 0;
    while (bus_req) begin
      n++; ns += stb;
      if (n == 50) begin wr_en = 1; kind = 2'b00; wdata = 16'd1; end // R9
      else if (n == 60) begin wr_en = 1; kind = 2'b10; end              // R2
      else begin wr_en = 0; kind = 2'b11; end
      @(negedge clk);
    end
    ns += stb;
    chk("R4 blanked duration", n, 267);
    chk("R4 strobe count", ns, 16);

    // idle mode write, active rate
    tag = "R7";
    @(negedge clk); wr_en = 1; kind = 2'b01; wdata = 16'd1;
    @(negedge clk); wr_en = 0; kind = 2'b11;
    chk("R7 idle disp_en", disp, 1);
    tag = "R5";
    wr(2'b00, 16'd4);
    wr(2'b10, 16'd0);
    n = 0; ns = 0;
    while (bus_req) begin n++; ns += stb; @(negedge clk); end
    ns += stb;
    chk("R5 active duration", n, 760);
    chk("R5 strobe count", ns, 4);

    // deferred enable: display off, then start + enable back to back
    tag = "R7";
    wr(2'b01, 16'd0);
    wr(2'b00, 16'd16);
    @(negedge clk); wr_en = 1; kind = 2'b10;
    @(negedge clk); kind = 2'b01; wdata = 16'd1;
    @(negedge clk); wr_en = 0; kind = 2'b11;
    n = 1;
    while (bus_req) begin
      chk("R7 disp held", disp, 0);
      n++; @(negedge clk);
    end
    chk("R7 deferred duration", n, 267);
    chk("R7 applied at release", disp, 1);

    // vblank toggles mid-transfer
    tag = "R6";
    wr(2'b00, 16'd10);
    wr(2'b10, 16'd0);
    repeat (200) @(negedge clk);
    vblank = 1;
    repeat (60) @(negedge clk);
    vblank = 0;
    repeat (30) @(negedge clk);
    vblank = 1;
    while (bus_req) @(negedge clk);
    chk("R6 released", bus_req, 0);

    // grant and master-clock gating
    tag = "R8";
    gnt = 0;
    wr(2'b00, 16'd3);
    wr(2'b10, 16'd0);
    ns = 0;
    repeat (100) begin ns += stb; @(negedge clk); end
    chk("R8 no strobe without grant", ns, 0);
    chk("R8 request held", bus_req, 1);
    gnt = 1;
    n = 0;
    while (bus_req) begin mclk_en = n[0]; n++; @(negedge clk); end
    mclk_en = 1;
    chk("R8 gated released", bus_req, 0);

    // zero length runs far past any 16-bit count
    tag = "R3";
    wr(2'b00, 16'd0);
    wr(2'b10, 16'd0);
    ns = 0;
    repeat (1000) begin ns += stb; @(negedge clk); end
    chk("R3 strobes in 1000 cycles", ns, 59);
    chk("R3 still requesting", bus_req, 1);
    report();
  end
endmodule